// File: doc/BRIEF.md
# Selectable-Depth Jitter Attenuator Bit FIFO

This block is an elastic single-bit buffer placed in a line interface's serial data path. Bits enter on a write clock that may be jittered, gapped or bursty. They leave on a separate read clock that is already smoothed; that clock comes from outside the block. The buffer can serve either the receive stream or the transmit stream. Whichever stream it does not serve passes straight through with no registers. A disable control takes the buffer out of both streams.

The working depth is 32 or 128 bits. The shallow depth suits delay-sensitive links, and the deep one absorbs large wander. The read pointer normally trails the write pointer by half the selected depth. The fill level is measured on the read side against a Gray-coded, two-flop-synchronized copy of the write pointer. If the fill comes within a guard band of empty or full, the block raises a sticky limit flag and moves the read pointer back to the half-depth separation. This gives about 24 UI peak-to-peak of tolerance at 32 bits and about 120 UI at 128 bits.

Top module: `jitter_fifo`

## Requirements
- R1: `deep_sel_i` = 1 selects a 128-bit working depth and 0 selects 32 bits. The limit condition is a fill level of at most 4 or at least depth minus 4, so a steady 5 % write-rate excess is tolerated much longer at 128 bits than at 32.
- R2: With `path_tx_i` = 0 the buffer serves the receive stream (`rx_bit_i` to `rx_bit_o`) and `tx_bit_o` follows `tx_bit_i` combinationally. With `path_tx_i` = 1 the roles swap.
- R3: With `bypass_i` = 1 both outputs follow their inputs combinationally and `limit_o` is cleared within one read clock. When `bypass_i` returns to 0 the pointers are recentred and no limit is reported under matched clocks.
- R4: On the served stream, the output bit sequence is the input bit sequence unchanged in order, delayed by a fixed latency.
- R5: `limit_o` is 0 during and after reset. After reset the read pointer starts half the selected depth behind the write pointer, so matched clocks never raise `limit_o`.
- R6: A change of `deep_sel_i` recentres the read pointer to half the new depth, so switching depth under matched clocks raises no limit.
- R7: On a guard-band hit `limit_o` goes to 1 and stays at 1 until disable or reset. The read pointer is moved to the half-depth separation, and bit order is preserved afterwards.
- R8: The write pointer crosses to the read clock as a Gray code, changing at most one bit per write clock, so data stays intact when the two clocks differ in rate.
- R9: A 20-bit gap in the write clock is absorbed without a limit at 128-bit depth, and raises `limit_o` at 32-bit depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset, both clock domains |
| wr_clk_i | input | 1 | Write clock of the served stream; may be gapped or bursty |
| rd_clk_i | input | 1 | Smoothed read clock |
| deep_sel_i | input | 1 | 1: 128-bit depth, 0: 32-bit depth (read-clock domain) |
| path_tx_i | input | 1 | 0: serve receive stream, 1: serve transmit stream |
| bypass_i | input | 1 | 1: remove buffer from both streams (read-clock domain) |
| rx_bit_i | input | 1 | Receive stream data in |
| tx_bit_i | input | 1 | Transmit stream data in |
| rx_bit_o | output | 1 | Receive stream data out |
| tx_bit_o | output | 1 | Transmit stream data out |
| limit_o | output | 1 | Sticky jitter-tolerance-exceeded flag |

## Verification
The hardest state to reach is the guard-band hit: at the ports it only appears after the two clock domains have drifted tens of bits apart. The bench gets there in two ways. It stops the write clock for a fixed number of read periods, and it runs the write clock about 5 % fast for hundreds to thousands of periods. The time to the flag shows which depth is in force. Data integrity is checked without knowing the exact latency. The served stream carries a 7-bit maximal-length sequence, with the transmit copy inverted, and every output bit must satisfy that sequence's recurrence.

// File: rtl/jafifo_pkg.sv
package jafifo_pkg;
  typedef enum logic {
    PATH_RX = 1'b0,
    PATH_TX = 1'b1
  } path_e;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/jafifo_sync.sv
module jafifo_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/jafifo_mem.sv
module jafifo_mem #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned AW    = 7
) (
  input  logic          wr_clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] waddr_i,
  input  logic          wbit_i,
  input  logic [AW-1:0] raddr_i,
  output logic          rbit_o
);
  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge wr_clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else         bits_q[waddr_i] <= wbit_i;
  end

  // safe: read address trails the write address by the Gray-synchronized margin
  assign rbit_o = bits_q[raddr_i];
endmodule

// File: rtl/jafifo_wr.sv
module jafifo_wr #(
  parameter int unsigned PTR_W = 8,
  localparam int unsigned AW   = PTR_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [AW-1:0]    addr_o,
  output logic [PTR_W-1:0] gray_o
);
  logic [PTR_W-1:0] bin_q, bin_nxt, gray_q;

  assign bin_nxt = bin_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_q <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

  assign addr_o = bin_q[AW-1:0];
  assign gray_o = gray_q;

  // R8
  gray_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/jafifo_rd.sv
module jafifo_rd #(
  parameter int unsigned PTR_W = 8,
  parameter int unsigned DEEP  = 128,
  parameter int unsigned SHAL  = 32,
  parameter int unsigned GUARD = 4,
  localparam int unsigned AW   = PTR_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             deep_sel_i,
  input  logic             bypass_i,
  input  logic [PTR_W-1:0] wr_gray_i,
  output logic [AW-1:0]    addr_o,
  output logic             rd_en_o,
  output logic             limit_o
);
  localparam logic [PTR_W-1:0] DEEP_P  = PTR_W'(DEEP);
  localparam logic [PTR_W-1:0] SHAL_P  = PTR_W'(SHAL);
  localparam logic [PTR_W-1:0] GUARD_P = PTR_W'(GUARD);

  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] rd_ptr_q, wr_bin, depth, half, fill;
  logic             started_q, deep_q, limit_q;
  logic             depth_chg, guard_hit, recenter;

  always_comb begin
    wr_bin    = gray2bin(wr_gray_i);
    depth     = deep_sel_i ? DEEP_P : SHAL_P;
    half      = depth >> 1;
    fill      = wr_bin - rd_ptr_q;
    depth_chg = deep_q != deep_sel_i;
    guard_hit = started_q && !depth_chg &&
                ((fill <= GUARD_P) || (fill >= depth - GUARD_P));
    recenter  = !bypass_i && (!started_q || depth_chg || guard_hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q  <= '0;
      started_q <= 1'b0;
      deep_q    <= 1'b0;
      limit_q   <= 1'b0;
    end else begin
      deep_q <= deep_sel_i;
      if (bypass_i) begin
        started_q <= 1'b0;
        limit_q   <= 1'b0;
      end else if (recenter) begin
        rd_ptr_q  <= wr_bin - half;
        started_q <= 1'b1;
        if (guard_hit) limit_q <= 1'b1;
      end else begin
        rd_ptr_q <= rd_ptr_q + 1'b1;
      end
    end
  end

  assign addr_o  = rd_ptr_q[AW-1:0];
  assign rd_en_o = !bypass_i && !recenter;
  assign limit_o = limit_q;

  // R7
  limit_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_q && !bypass_i) |=> limit_q);

  // R3
  bypass_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> !limit_q);

  // R1
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && !bypass_i && !depth_chg) |-> (fill <= depth));

  // R6
  recenter_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && !bypass_i && depth_chg) |=>
      ((fill >= half) && (fill <= half + PTR_W'(2))));
endmodule

// File: rtl/jitter_fifo.sv
module jitter_fifo #(
  parameter int unsigned DEEP_BITS   = 128,
  parameter int unsigned SHAL_BITS   = 32,
  parameter int unsigned GUARD_BITS  = 4,
  parameter int unsigned SYNC_STAGES = jafifo_pkg::SYNC_DEPTH
) (
  input  logic rst_ni,
  input  logic wr_clk_i,
  input  logic rd_clk_i,
  input  logic deep_sel_i,
  input  logic path_tx_i,
  input  logic bypass_i,
  input  logic rx_bit_i,
  input  logic tx_bit_i,
  output logic rx_bit_o,
  output logic tx_bit_o,
  output logic limit_o
);
  import jafifo_pkg::*;

  localparam int unsigned PTR_W = $clog2(DEEP_BITS) + 1;
  localparam int unsigned AW    = PTR_W - 1;

  path_e            path;
  logic             wr_bit, mem_bit, rd_en, rd_bit_q;
  logic [AW-1:0]    waddr, raddr;
  logic [PTR_W-1:0] wr_gray, wr_gray_sync;

  assign path   = path_e'(path_tx_i);
  assign wr_bit = (path == PATH_TX) ? tx_bit_i : rx_bit_i;

  jafifo_wr #(.PTR_W(PTR_W)) u_wr (
    .clk_i  (wr_clk_i),
    .rst_ni (rst_ni),
    .addr_o (waddr),
    .gray_o (wr_gray)
  );

  jafifo_mem #(.DEPTH(1 << AW), .AW(AW)) u_mem (
    .wr_clk_i (wr_clk_i),
    .rst_ni   (rst_ni),
    .waddr_i  (waddr),
    .wbit_i   (wr_bit),
    .raddr_i  (raddr),
    .rbit_o   (mem_bit)
  );

  jafifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (rd_clk_i),
    .rst_ni (rst_ni),
    .d_i    (wr_gray),
    .q_o    (wr_gray_sync)
  );

  jafifo_rd #(
    .PTR_W (PTR_W),
    .DEEP  (DEEP_BITS),
    .SHAL  (SHAL_BITS),
    .GUARD (GUARD_BITS)
  ) u_rd (
    .clk_i      (rd_clk_i),
    .rst_ni     (rst_ni),
    .deep_sel_i (deep_sel_i),
    .bypass_i   (bypass_i),
    .wr_gray_i  (wr_gray_sync),
    .addr_o     (raddr),
    .rd_en_o    (rd_en),
    .limit_o    (limit_o)
  );

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni)    rd_bit_q <= 1'b0;
    else if (rd_en) rd_bit_q <= mem_bit;
  end

  assign rx_bit_o = (!bypass_i && path == PATH_RX) ? rd_bit_q : rx_bit_i;
  assign tx_bit_o = (!bypass_i && path == PATH_TX) ? rd_bit_q : tx_bit_i;
endmodule

// File: tb/tb_jitter_fifo.sv
`timescale 1ns/100ps
module tb_jitter_fifo;
  logic rst_ni = 1'b0;
  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic deep_sel = 1'b1, path_tx = 1'b0, bypass = 1'b0;
  logic rx_man = 1'b0, tx_man = 1'b0, drive_prbs = 1'b0;
  logic rx_bit_i, tx_bit_i, rx_bit_o, tx_bit_o, limit_o;
  logic [6:0] lfsr = 7'h5A;
  logic wr_run = 1'b1;
  real  wr_half = 4.0;
  int   n_chk = 0, n_bad = 0;

  // [7]bypass [6]path_tx [5]rx_in [4]tx_in [3]chk_rx [2]chk_tx [1]exp_rx [0]exp_tx
  localparam logic [7:0] VEC [8] = '{
    8'b1_0_0_1_1_1_0_1,  // R3
    8'b1_0_1_0_1_1_1_0,  // R3
    8'b1_1_1_1_1_1_1_1,  // R3
    8'b1_1_0_0_1_1_0_0,  // R3
    8'b0_0_0_0_0_1_0_0,  // R2 tx passes
    8'b0_0_0_1_0_1_0_1,  // R2
    8'b0_1_0_0_1_0_0_0,  // R2 rx passes
    8'b0_1_1_0_1_0_1_0   // R2
  };

  jitter_fifo dut (
    .rst_ni     (rst_ni),
    .wr_clk_i   (wr_clk),
    .rd_clk_i   (rd_clk),
    .deep_sel_i (deep_sel),
    .path_tx_i  (path_tx),
    .bypass_i   (bypass),
    .rx_bit_i   (rx_bit_i),
    .tx_bit_i   (tx_bit_i),
    .rx_bit_o   (rx_bit_o),
    .tx_bit_o   (tx_bit_o),
    .limit_o    (limit_o)
  );

  always #4 rd_clk = ~rd_clk;

  initial begin
    #1.3;
    forever begin
      #(wr_half);
      if (wr_run) wr_clk = ~wr_clk;
      else        wr_clk = 1'b0;
    end
  end

  // x^7 + x^6 + 1: b[n] = b[n-6] ^ b[n-7]
  always @(negedge wr_clk) lfsr <= {lfsr[5:0], lfsr[5] ^ lfsr[6]};
  assign rx_bit_i = drive_prbs ?  lfsr[0] : rx_man;
  assign tx_bit_i = drive_prbs ? ~lfsr[0] : tx_man;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd_cycles(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic chk_stream(input bit on_tx, input int n, input string req);
    logic [6:0] h = '0;
    int bad = 0, ones = 0;
    for (int k = 0; k < n; k++) begin
      logic b, e;
      @(negedge rd_clk);
      b = on_tx ? tx_bit_o : rx_bit_o;
      e = h[5] ^ h[6] ^ on_tx;
      if (k >= 7 && b !== e) bad++;
      if (b === 1'b1) ones++;
      h = {h[5:0], b};
    end
    check(bad == 0 && ones > n / 4 && ones < 3 * n / 4, req, bad, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rd_cycles(5);
    check(limit_o == 1'b0, "R5 reset", limit_o, 0);
    rst_ni = 1'b1;
    rd_cycles(20);
    check(limit_o == 1'b0, "R5 after reset", limit_o, 0);

    for (int v = 0; v < 8; v++) begin
      bypass  = VEC[v][7];
      path_tx = VEC[v][6];
      rx_man  = VEC[v][5];
      tx_man  = VEC[v][4];
      #1;
      if (VEC[v][3]) check(rx_bit_o == VEC[v][1], "R2/R3 rx passthrough", rx_bit_o, VEC[v][1]);
      if (VEC[v][2]) check(tx_bit_o == VEC[v][0], "R2/R3 tx passthrough", tx_bit_o, VEC[v][0]);
      rd_cycles(1);
    end

    bypass = 1'b0; path_tx = 1'b0; drive_prbs = 1'b1;
    rd_cycles(300);
    check(limit_o == 1'b0, "R5 matched clocks", limit_o, 0);
    chk_stream(1'b0, 200, "R4 rx order");

    path_tx = 1'b1;
    rd_cycles(300);
    chk_stream(1'b1, 200, "R2 tx served");

    deep_sel = 1'b0;
    rd_cycles(300);
    check(limit_o == 1'b0, "R6 128->32", limit_o, 0);
    chk_stream(1'b1, 200, "R1 32-bit order");

    deep_sel = 1'b1;
    rd_cycles(200);
    check(limit_o == 1'b0, "R6 32->128", limit_o, 0);

    wr_run = 1'b0; rd_cycles(20); wr_run = 1'b1;
    rd_cycles(100);
    check(limit_o == 1'b0, "R9 gap at 128", limit_o, 0);

    deep_sel = 1'b0;
    rd_cycles(200);
    check(limit_o == 1'b0, "R6 recentre before gap", limit_o, 0);
    wr_run = 1'b0; rd_cycles(20); wr_run = 1'b1;
    rd_cycles(50);
    check(limit_o == 1'b1, "R9 gap at 32", limit_o, 1);

    rd_cycles(300);
    check(limit_o == 1'b1, "R7 sticky", limit_o, 1);
    chk_stream(1'b1, 200, "R7 order after recentre");

    bypass = 1'b1;
    rd_cycles(3);
    check(limit_o == 1'b0, "R3 clear", limit_o, 0);
    bypass = 1'b0;
    rd_cycles(300);
    check(limit_o == 1'b0, "R3 resume", limit_o, 0);

    deep_sel = 1'b1; wr_half = 3.8;
    rd_cycles(150);
    chk_stream(1'b1, 200, "R8 fast write order");
    rd_cycles(50);
    check(limit_o == 1'b0, "R1 128 fast early", limit_o, 0);
    rd_cycles(2600);
    check(limit_o == 1'b1, "R1 128 fast late", limit_o, 1);

    bypass = 1'b1;
    rd_cycles(2);
    bypass = 1'b0; deep_sel = 1'b0;
    rd_cycles(600);
    check(limit_o == 1'b1, "R1 32 fast", limit_o, 1);

    finish_run();
  end
endmodule